// File: doc/BRIEF.md
# Dual-Method Switch Debouncer

This block takes one raw, bouncing switch contact and turns it into a clean level plus a single-cycle pulse that marks each accepted change. The raw contact first passes through a short chain of synchronizing flops. A one-bit method select then chooses which of two filters may update the output.

The first filter is a delayed confirmation. When the synchronized input differs from the current output, the block records that first sample and waits a fixed number of clock cycles. It then samples the input a second time. The output moves to the new level only if the second sample agrees with the first. If it does not agree, the output is left alone and the filter goes back to watching.

The second filter is a vote over N samples. Samples are taken at a fixed spacing, and each group of N samples is one window. At the end of each window the output takes the rounded mean of the window. For even N, a window with exactly half ones keeps the previous level. All timing parameters are counted in clock cycles, and both filters run all the time. The select only decides which filter's result reaches the output. The pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `sw_debounce`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sw_level` is 0 and `sw_toggle` is 0.
- R2: With `use_vote` = 0, the raw input may change and then hold steady. Count edges from the first clock edge at which the new raw value is present. After exactly SYNC_STAGES + 1 + CONFIRM_CYCLES edges, `sw_level` takes the new value, and it does not take it before then.
- R3: With `use_vote` = 0, the second sample may disagree with the first one (for example, a short glitch). In that case `sw_level` stays unchanged, no `sw_toggle` pulse appears, and a later steady change is still accepted.
- R4: With `use_vote` = 0, bouncing that settles before the confirmation sample produces exactly one accepted change to the settled level.
- R5: With `use_vote` = 1, a sample of the synchronized input is taken at every edge k·VOTE_SPACING after reset is released (k = 1, 2, …). The raw value seen SYNC_STAGES edges before that edge is the one sampled. Ticks k = mN+1 … mN+N form one window, and the output is updated at tick (m+1)N.
- R6: In vote mode, a window whose count of ones times 2 is greater than N drives `sw_level` to 1. A window whose count times 2 is less than N drives it to 0.
- R7: In vote mode, when twice the count of ones equals N (possible only for even N), `sw_level` keeps its previous value.
- R8: `sw_toggle` is high for exactly one cycle, namely the first cycle in which `sw_level` shows a new value. It is never high otherwise.
- R9: Changing `use_vote` by itself does not change `sw_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_raw | input | 1 | Raw switch contact, asynchronous |
| use_vote | input | 1 | Method select: 0 = delayed confirmation, 1 = N-sample vote |
| sw_level | output | 1 | Filtered switch level |
| sw_toggle | output | 1 | One-cycle pulse when `sw_level` changes |

## Verification
In confirmation mode the new level is due SYNC_STAGES + 1 + CONFIRM_CYCLES edges after the raw change is first sampled. The bench checks the cycle before that (old level, no pulse), the due cycle (new level, pulse) and the cycle after (pulse gone). In vote mode, decisions fall on the edges N·VOTE_SPACING·m after reset. The bench counts edges from reset release, drives each raw sample SYNC_STAGES edges ahead of its tick, and reads the output just after each decision edge. It sweeps every N-bit pattern, for one odd and one even N. Glitch and bounce cases are watched over windows several times longer than the confirmation delay.

// File: rtl/swdb_pkg.sv
package swdb_pkg;
  typedef enum logic {
    METH_CONFIRM = 1'b0,
    METH_VOTE    = 1'b1
  } meth_e;

  // counter width able to hold values 0 .. n-1
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/swdb_sync.sv
module swdb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swdb_confirm.sv
module swdb_confirm #(
  parameter int DELAY = 750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic cur,
  output logic acc,
  output logic acc_val
);
  localparam int CW = swdb_pkg::cnt_w(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  typedef enum logic {WATCH, HOLD} st_e;
  st_e            st;
  logic [CW-1:0]  cnt;
  logic           first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= WATCH;
      cnt   <= '0;
      first <= 1'b0;
    end else begin
      case (st)
        WATCH: if (din != cur) begin
          st    <= HOLD;
          cnt   <= '0;
          first <= din;
        end
        HOLD: if (cnt == LAST) st <= WATCH;
              else             cnt <= cnt + 1'b1;
        default: st <= WATCH;
      endcase
    end
  end

  // second sample must agree with the first one
  assign acc     = (st == HOLD) && (cnt == LAST) && (din == first);
  assign acc_val = first;

  // R2: the wait never runs past its limit
  a_r2_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD) |-> (cnt <= LAST));

  // R3: after the confirmation sample the filter watches again
  a_r3_back_to_watch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD && cnt == LAST) |=> (st == WATCH));
endmodule

// File: rtl/swdb_vote.sv
module swdb_vote #(
  parameter int N       = 5,
  parameter int SPACING = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic vld,
  output logic val,
  output logic tie
);
  localparam int TW = swdb_pkg::cnt_w(SPACING);
  localparam int IW = swdb_pkg::cnt_w(N);
  localparam int OW = $clog2(N + 1);
  localparam logic [TW-1:0] TLAST = TW'(SPACING - 1);
  localparam logic [IW-1:0] ILAST = IW'(N - 1);
  localparam logic [OW:0]   NREF  = (OW + 1)'(N);

  logic [TW-1:0] tcnt;
  logic [IW-1:0] idx;
  logic [OW-1:0] ones;
  logic [OW-1:0] total;
  logic [OW:0]   dbl;
  logic          tick;

  assign tick = (tcnt == TLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      idx  <= '0;
      ones <= '0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick) begin
        if (idx == ILAST) begin
          idx  <= '0;
          ones <= '0;
        end else begin
          idx  <= idx + 1'b1;
          ones <= ones + OW'(din);
        end
      end
    end
  end

  assign total = ones + OW'(din);
  assign dbl   = {total, 1'b0};
  assign vld   = tick && (idx == ILAST);
  assign val   = dbl > NREF;
  assign tie   = dbl == NREF;

  // R5: ones counted never exceed samples taken in the window
  a_r5_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ones} <= (OW + 1)'(idx)));

  // R5: sample index stays inside the window
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (idx <= ILAST));
endmodule

// File: rtl/sw_debounce.sv
module sw_debounce #(
  parameter int SYNC_STAGES    = 2,
  parameter int CONFIRM_CYCLES = 750000,
  parameter int VOTE_N         = 5,
  parameter int VOTE_SPACING   = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_raw,
  input  logic use_vote,
  output logic sw_level,
  output logic sw_toggle
);
  import swdb_pkg::*;

  meth_e meth;
  logic  din_s;
  logic  c_acc, c_val;
  logic  v_vld, v_val, v_tie;
  logic  upd, nxt;

  assign meth = meth_e'(use_vote);

  swdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sw_raw), .q(din_s)
  );

  swdb_confirm #(.DELAY(CONFIRM_CYCLES)) u_conf (
    .clk(clk), .rst_n(rst_n), .din(din_s), .cur(sw_level),
    .acc(c_acc), .acc_val(c_val)
  );

  swdb_vote #(.N(VOTE_N), .SPACING(VOTE_SPACING)) u_vote (
    .clk(clk), .rst_n(rst_n), .din(din_s),
    .vld(v_vld), .val(v_val), .tie(v_tie)
  );

  always_comb begin
    if (meth == METH_VOTE) begin
      upd = v_vld && !v_tie;
      nxt = v_val;
    end else begin
      upd = c_acc;
      nxt = c_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_level  <= 1'b0;
      sw_toggle <= 1'b0;
    end else begin
      if (upd) sw_level <= nxt;
      sw_toggle <= upd && (nxt != sw_level);
    end
  end

  // R8: a pulse always comes with a new level
  a_r8_pulse_has_change: assert property (@(posedge clk) disable iff (!rst_n)
    sw_toggle |-> (sw_level != $past(sw_level)));

  // R8: a new level always comes with a pulse
  a_r8_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_level != $past(sw_level)) |-> sw_toggle);

  // R7: a tied window leaves the level alone
  a_r7_tie_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (meth == METH_VOTE && v_vld && v_tie) |=> $stable(sw_level));

  // R9: without an accepted confirmation the level cannot move in that mode
  a_r9_confirm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (meth == METH_CONFIRM && !c_acc) |=> $stable(sw_level));
endmodule

// File: tb/sw_debounce_test.sv
`timescale 1ns/1ps
module sw_debounce_test;
  localparam int SY = 2;
  localparam int CD = 8;
  localparam int NA = 5;
  localparam int NB = 4;
  localparam int SP = 6;
  localparam int LAT = SY + 1 + CD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_a = 1'b0;
  logic raw_b = 1'b0;
  logic mode = 1'b1;
  logic lvl_a, tog_a, lvl_b, tog_b;

  int cyc = 0;
  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  sw_debounce #(.SYNC_STAGES(SY), .CONFIRM_CYCLES(CD), .VOTE_N(NA), .VOTE_SPACING(SP)) uut (
    .clk(clk), .rst_n(rst_n), .sw_raw(raw_a), .use_vote(mode),
    .sw_level(lvl_a), .sw_toggle(tog_a));

  sw_debounce #(.SYNC_STAGES(SY), .CONFIRM_CYCLES(CD), .VOTE_N(NB), .VOTE_SPACING(SP)) uut_even (
    .clk(clk), .rst_n(rst_n), .sw_raw(raw_b), .use_vote(mode),
    .sw_level(lvl_b), .sw_toggle(tog_b));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // exhaustive vote sweep over all n-bit windows, samples in bit order
  task automatic sweep(input bit which, input int n, input int npat);
    int k0, ks, w, b, ones;
    logic prev, exp;
    prev = 1'b0;
    k0 = (cyc + SY + SP - 1) / SP;
    ks = ((k0 + n - 1) / n) * n;
    for (int t = ks; t <= ks + n * npat; t++) begin
      wait_cyc(t * SP - SY);
      if (t < ks + n * npat) begin
        w = (t - ks) / n;
        b = (t - ks) % n;
        if (which) raw_b = w[b]; else raw_a = w[b];
      end
      wait_cyc(t * SP);
      if (t > ks && (t - ks) % n == 0) begin
        w = (t - ks) / n - 1;
        ones = 0;
        for (int i = 0; i < n; i++) ones += w[i];
        if (2 * ones > n)      exp = 1'b1;   // R6
        else if (2 * ones < n) exp = 1'b0;   // R6
        else                   exp = prev;   // R7
        if (which) begin
          chk((2 * ones == n) ? "R7 tie level" : "R6 vote level", lvl_b, exp);
          chk("R8 vote toggle", tog_b, exp != prev);
        end else begin
          chk("R5/R6 vote level", lvl_a, exp);
          chk("R8 vote toggle", tog_a, exp != prev);
        end
        prev = exp;
      end
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(4 * 60000);
    errs++;
    checks++;
    $display("FAIL watchdog expired (cycle %0d)", cyc);
    summary();
    $finish;
  end

  initial begin
    int c0, n;
    logic bad;
    repeat (3) @(negedge clk);
    chk("R1 reset level", lvl_a, 1'b0);
    chk("R1 reset toggle", tog_a, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 level after release", lvl_b, 1'b0);
    chk("R1 toggle after release", tog_b, 1'b0);

    // vote mode: odd N, then even N with ties
    sweep(1'b0, NA, 1 << NA);
    sweep(1'b1, NB, 1 << NB);

    // R9: switch to confirmation, level must not move by itself
    mode = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (lvl_a !== 1'b1 || lvl_b !== 1'b1 || tog_a || tog_b) bad = 1'b1;
    end
    chk("R9 mode switch holds level", bad, 1'b0);

    // R2: falling change, exact latency
    c0 = cyc; raw_a = 1'b0;
    wait_cyc(c0 + LAT - 1);
    chk("R2 level before due", lvl_a, 1'b1);
    chk("R8 no early toggle", tog_a, 1'b0);
    wait_cyc(c0 + LAT);
    chk("R2 level at due", lvl_a, 1'b0);
    chk("R8 toggle at due", tog_a, 1'b1);
    wait_cyc(c0 + LAT + 1);
    chk("R8 toggle one cycle", tog_a, 1'b0);
    wait_cyc(c0 + LAT + 6);

    // R2: rising change
    c0 = cyc; raw_a = 1'b1;
    wait_cyc(c0 + LAT - 1);
    chk("R2 rise before due", lvl_a, 1'b0);
    wait_cyc(c0 + LAT);
    chk("R2 rise at due", lvl_a, 1'b1);
    chk("R8 rise toggle", tog_a, 1'b1);
    wait_cyc(c0 + LAT + 6);

    // R3: glitch rejected by the second sample
    c0 = cyc; raw_a = 1'b0;
    wait_cyc(c0 + 3); raw_a = 1'b1;
    n = 0; bad = 1'b0;
    while (cyc < c0 + 4 * LAT) begin
      @(negedge clk);
      if (tog_a) n++;
      if (lvl_a !== 1'b1) bad = 1'b1;
    end
    chk("R3 glitch no toggle", n == 0, 1'b1);
    chk("R3 glitch level held", bad, 1'b0);

    // R4: bouncing press settles to 0, exactly one change
    c0 = cyc; raw_a = 1'b0;
    wait_cyc(c0 + 1); raw_a = 1'b1;
    wait_cyc(c0 + 2); raw_a = 1'b0;
    wait_cyc(c0 + 3); raw_a = 1'b1;
    wait_cyc(c0 + 4); raw_a = 1'b0;
    n = 0;
    while (cyc < c0 + 5 * LAT) begin
      @(negedge clk);
      if (tog_a) n++;
    end
    chk("R4 bounce single toggle", n == 1, 1'b1);
    chk("R4 bounce final level", lvl_a, 1'b0);

    // R3: filter back to watching, steady change accepted
    c0 = cyc; raw_a = 1'b1;
    wait_cyc(c0 + LAT);
    chk("R3 accepts after reject", lvl_a, 1'b1);

    summary();
    $finish;
  end
endmodule